// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Insertion

This block turns bytes into asynchronous serial frames on a single output line. A byte is written into a one-entry holding register. At the next baud tick with the line free, the byte moves into a shift register. The shift register then sends a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts from one baud tick to the next. If a byte is queued while a frame is on the line, it follows the stop bit with no idle gap.

A send-break request replaces data with break frames. A break frame is a full frame length with the line held low. If a data frame is on the line when break is requested, that frame finishes unchanged. Break frames then repeat for as long as the request stays high. A request that rises and falls between baud ticks is latched, so it still produces a whole break frame. A byte waiting in the holding register is sent after the break ends.

Two flags report progress. The data-empty flag shows that a new byte may be written. The transmit-complete flag shows that nothing is on the line or queued.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, txLine, dataEmpty and txComplete are all 1.
- R2: A data frame is ten bit periods, each lasting one baudTick interval. In order on txLine: start bit 0, wrData[0] up to wrData[7], then stop bit 1. The first bit appears after the first baudTick that sees a queued byte and no frame in progress.
- R3: dataEmpty goes to 0 in the cycle after wrStrobe. It returns to 1 after the baudTick that moves the held byte into the shifter.
- R4: If a second write arrives while dataEmpty is 0, it replaces the pending byte. Only the last byte written is sent.
- R5: A byte queued during a frame starts on the baudTick that ends that frame's stop bit, with no idle bit in between.
- R6: txComplete is 0 while a frame is on the line, while a byte is held, or while a break is pending. Otherwise it is 1, and txLine is then 1.
- R7: If sendBreak goes high during a data frame, that frame completes unchanged. After it, frames of ten zero bit periods repeat for as long as sendBreak is high at each frame boundary.
- R8: A sendBreak pulse shorter than one bit period, given while idle, yields exactly one complete ten-period break frame, after which the line returns to 1.
- R9: A byte written during a break is held until the break ends and is then sent as a normal frame.
- R10: Dropping sendBreak partway through a break frame does not shorten that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| wrStrobe | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Byte to be written |
| sendBreak | input | 1 | Request for break frames |
| txLine | output | 1 | Serial output line, idle high |
| dataEmpty | output | 1 | Holding register free for a new byte |
| txComplete | output | 1 | Nothing on the line or queued |

## Verification
The assertions assume that baudTick is a single-cycle pulse. They also assume that wrStrobe never falls in the same cycle as baudTick, so that the check of the empty flag after a transfer is not masked by a new write. The stimulus meets both assumptions. It raises baudTick for exactly one clock, followed by an idle clock. It applies writes and sendBreak changes only in clocks that lie between ticks.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef struct packed {
    logic writeHold;
    logic loadData;
    logic loadBreak;
    logic shift;
  } txStrobes_t;
endpackage

// File: rtl/uart_brk_dp.sv
module uart_brk_dp
  import uart_brk_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           strb,
  input  logic [DATA_BITS-1:0] wrData,
  output logic                 txLine
);
  localparam int FRAME_BITS = DATA_BITS + 2;

  logic [DATA_BITS-1:0]  holdReg;
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (strb.writeHold) holdReg <= wrData;
      if (strb.loadBreak)
        shiftReg <= '0;
      else if (strb.loadData)
        shiftReg <= {1'b1, holdReg, 1'b0};
      else if (strb.shift)
        shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end
  end

  assign txLine = shiftReg[0];

  AST_BREAK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBreak |=> !txLine); // R7
  AST_DATA_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |=> !txLine); // R2
endmodule

// File: rtl/uart_brk_ctrl.sv
module uart_brk_ctrl
  import uart_brk_pkg::*;
#(
  parameter int FRAME_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       wrStrobe,
  input  logic       sendBreak,
  output txStrobes_t strb,
  output logic       dataEmpty,
  output logic       txComplete
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             brkPend;
  logic             sbkQ;
  logic             frameEnd;
  logic             boundary;
  logic             wantBreak;

  always_comb begin
    frameEnd       = busy && (bitCnt == LAST_BIT);
    boundary       = baudTick && (!busy || frameEnd);
    wantBreak      = brkPend || sendBreak;
    strb.writeHold = wrStrobe;
    strb.loadBreak = boundary && wantBreak;
    strb.loadData  = boundary && !wantBreak && !dataEmpty;
    strb.shift     = baudTick && !strb.loadBreak && !strb.loadData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      bitCnt    <= '0;
      brkPend   <= 1'b0;
      sbkQ      <= 1'b0;
      dataEmpty <= 1'b1;
    end else begin
      sbkQ <= sendBreak;
      if (strb.loadBreak)             brkPend <= 1'b0;
      else if (sendBreak && !sbkQ)    brkPend <= 1'b1;
      if (wrStrobe)                   dataEmpty <= 1'b0;
      else if (strb.loadData)         dataEmpty <= 1'b1;
      if (baudTick) begin
        if (strb.loadData || strb.loadBreak) begin
          busy   <= 1'b1;
          bitCnt <= '0;
        end else if (frameEnd) begin
          busy   <= 1'b0;
        end else if (busy) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign txComplete = !busy && dataEmpty && !brkPend;

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !dataEmpty); // R3
  AST_TRANSFER_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData && !wrStrobe) |=> dataEmpty); // R3
  AST_NO_MIDFRAME_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameEnd) |-> !(strb.loadData || strb.loadBreak)); // R7
  AST_BREAK_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && sendBreak) |-> !strb.loadData); // R9
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 wrStrobe,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 sendBreak,
  output logic                 txLine,
  output logic                 dataEmpty,
  output logic                 txComplete
);
  localparam int FRAME_BITS = DATA_BITS + 2;

  txStrobes_t strb;

  uart_brk_ctrl #(.FRAME_BITS(FRAME_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrStrobe(wrStrobe),
    .sendBreak(sendBreak), .strb(strb), .dataEmpty(dataEmpty),
    .txComplete(txComplete)
  );

  uart_brk_dp #(.DATA_BITS(DATA_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .txLine(txLine)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txComplete |-> txLine); // R6
endmodule

// File: tb/tb_uart_brk_tx.sv
`timescale 1ns/1ps
module tb_uart_brk_tx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       sendBreak = 1'b0;
  logic       txLine, dataEmpty, txComplete;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_brk_tx dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrStrobe(wrStrobe),
    .wrData(wrData), .sendBreak(sendBreak), .txLine(txLine),
    .dataEmpty(dataEmpty), .txComplete(txComplete)
  );

  // {byte, expected frame bits, frame[0] sent first}
  localparam int NVEC = 5;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'hA5, 10'h34A}, {8'h00, 10'h200}, {8'hFF, 10'h3FE},
    {8'h3C, 10'h278}, {8'h81, 10'h302}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk); wrData = b; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0;
  endtask

  task automatic step();
    @(negedge clk); baudTick = 1'b1;
    @(negedge clk); baudTick = 1'b0;
  endtask

  // One whole frame; optional write and sendBreak change at given steps.
  task automatic runFrame(input logic [9:0] exp, input bit isData,
                          input int wrAt, input logic [7:0] wrB,
                          input int brkAt, input logic brkVal);
    for (int s = 0; s < 10; s++) begin
      step();
      check("R2/R7 line bit", txLine, exp[s]);
      check("R6 busy", txComplete, 1'b0);
      if (s == 0 && isData) check("R3 transfer sets empty", dataEmpty, 1'b1);
      if (s == wrAt) writeByte(wrB);
      if (s == brkAt) begin @(negedge clk); sendBreak = brkVal; end
    end
  endtask

  task automatic expectIdle(input string req);
    step();
    check({req, " idle line"}, txLine, 1'b1);
    check({req, " complete"}, txComplete, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 line", txLine, 1'b1);
    check("R1 empty", dataEmpty, 1'b1);
    check("R1 complete", txComplete, 1'b1);

    // R2, R5: table of bytes, each next byte queued during the previous frame
    writeByte(VEC[0][17:10]);
    check("R3 write clears empty", dataEmpty, 1'b0);
    check("R6 queued byte", txComplete, 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      if (i < NVEC - 1) runFrame(VEC[i][9:0], 1'b1, 2, VEC[i+1][17:10], -1, 1'b0);
      else              runFrame(VEC[i][9:0], 1'b1, -1, 8'h00, -1, 1'b0);
    end
    expectIdle("R5");

    // R4: overwrite pending byte
    writeByte(8'h11);
    writeByte(8'h5A);
    runFrame({1'b1, 8'h5A, 1'b0}, 1'b1, -1, 8'h00, -1, 1'b0);
    expectIdle("R4");

    // R7, R9, R10: break raised mid frame, byte queued during break
    writeByte(8'hC3);
    runFrame(10'h386, 1'b1, -1, 8'h00, 1, 1'b1);
    runFrame(10'h000, 1'b0, 3, 8'h96, -1, 1'b0);
    check("R9 byte held during break", dataEmpty, 1'b0);
    runFrame(10'h000, 1'b0, -1, 8'h00, 4, 1'b0);
    runFrame(10'h32C, 1'b1, -1, 8'h00, -1, 1'b0);
    expectIdle("R10");

    // R8: short pulse while idle gives exactly one break frame
    @(negedge clk); sendBreak = 1'b1;
    @(negedge clk); sendBreak = 1'b0;
    @(negedge clk);
    check("R6 pending break", txComplete, 1'b0);
    check("R8 line before tick", txLine, 1'b1);
    runFrame(10'h000, 1'b0, -1, 8'h00, -1, 1'b0);
    expectIdle("R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule